// File: doc/BRIEF.md
# Flash Write-Protection Gate

This block stands between the asynchronous control strobes of a parallel flash-style bus and the internal program and erase machinery. Each strobe edge is seen through a synchronizer clocked by a system clock faster than the bus. A write is passed to the command tracker only when the chip-enable, output-enable and write-enable levels form a legal write. It must also have started with a write-enable falling edge seen after reset, and the supply-lockout flag must be clear. The tracker accepts a short unlock-and-operation sequence and only then raises a one-cycle program or erase request. Any stray write sends it back to read mode.

Eight per-sector protect bits are held in a register and are indexed by the top three address bits. A program or erase aimed at a protected sector is dropped without a request. Protect and unprotect operations are carried out while the high-voltage detect flags for the output-enable and address-9 pins are both present. Such an operation runs from a write-enable falling edge to the next rising edge. Unprotect clears every bit, but only when all eight are already set. A status output reports whether the last such operation was accepted.

Top module: `flash_wp_gate`

The command tracker has five states:
- CS_READ is read mode.
- CS_UNLK1 means the first key has been seen.
- CS_UNLK2 means the second key has been seen.
- CS_PGM means armed for program.
- CS_ERS means armed for erase.

Its transitions are:
- CS_READ goes to CS_UNLK1 on 0xAA written at command address 0x555.
- CS_UNLK1 goes to CS_UNLK2 on 0x55 written at 0x2AA.
- CS_UNLK2 goes to CS_PGM on 0xA0 at 0x555, or to CS_ERS on 0x80 at 0x555.
- CS_PGM returns to CS_READ on the next write, issuing a program request.
- CS_ERS returns to CS_READ on the next write, issuing an erase request only when the data is 0x30.
- Any other write, and any cycle with lockout asserted, forces CS_READ.

The protect engine has two states, PS_IDLE and PS_PULSE. PS_IDLE goes to PS_PULSE on a falling write-enable edge in high-voltage mode with chip-enable low. PS_PULSE applies the operation and returns to PS_IDLE on the rising edge. It aborts to PS_IDLE if high-voltage mode, chip-enable or the supply goes away.

## Requirements
- R1: After reset the tracker is in read mode (`in_read`=1), both request outputs are 0, `sect_lock` equals the PROT_INIT parameter (0 by default) and `lock_op_ok` is 0.
- R2: If write-enable is already low when reset is released, with chip-enable low and output-enable high, the following rising edge of write-enable is not taken as a command cycle.
- R3: A command cycle is taken only on a write-enable rising edge with chip-enable low and output-enable high. A strobe with output-enable low or chip-enable high is ignored and leaves the tracker state unchanged.
- R4: While `supply_low` is 1 the tracker returns to read mode, no request is issued, no write is taken and `sect_lock` does not change.
- R5: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by a fourth write, produce exactly one `pgm_req` pulse. The pulse carries the fourth write's address and data on `req_addr` and `req_data`. Command addresses compare address bits 10:0.
- R6: The writes 0xAA@0x555, 0x55@0x2AA and 0x80@0x555, followed by 0x30 at any address, produce exactly one `ers_req` pulse with that address on `req_addr`.
- R7: A write that does not match the expected step returns the tracker to read mode without any request.
- R8: A program or erase whose sector (address bits 18:16) has its `sect_lock` bit set produces no request, and the tracker returns to read mode.
- R9: In high-voltage mode (both detect flags 1), a write-enable low pulse with chip-enable low and address bit 6 = 0 sets `sect_lock[addr[18:16]]` and sets `lock_op_ok` to 1. No command cycle is taken in this mode.
- R10: An unprotect (same pulse with address bit 6 = 1) clears all of `sect_lock` and sets `lock_op_ok` to 1 only when all eight bits are set. Otherwise `sect_lock` is unchanged and `lock_op_ok` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus |
| rst_n | input | 1 | Active-low reset (power-up) |
| bus_ce_n | input | 1 | Chip-enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output-enable, active low, asynchronous |
| bus_we_n | input | 1 | Write-enable, active low, asynchronous |
| bus_addr | input | 19 | Bus address, held stable around the strobe |
| bus_data | input | 8 | Bus write data, held stable around the strobe |
| supply_low | input | 1 | Supply-lockout flag |
| hv_oe_det | input | 1 | High voltage detected on output-enable pin |
| hv_a9_det | input | 1 | High voltage detected on address-9 pin |
| pgm_req | output | 1 | One-cycle program request |
| ers_req | output | 1 | One-cycle sector-erase request |
| req_addr | output | 19 | Address for the current request |
| req_data | output | 8 | Data for the current program request |
| sect_lock | output | 8 | Per-sector protect bits |
| lock_op_ok | output | 1 | Last protect/unprotect accepted |
| in_read | output | 1 | Tracker is in read mode |

## Verification
A write-enable rising edge at the pin passes two synchronizer flops and one edge-detect flop. The request flop then drives `pgm_req`/`ers_req` for one cycle at the third clock edge after the pin edge. `sect_lock` and `lock_op_ok` change at that same edge. The bench holds address, data and chip-enable for four cycles after each rising edge. It counts request pulses on the falling clock edge, so every check of counts, captured addresses and protect bits is made only after the results are due. Tracker state is observed through `in_read` or through whether a later sequence completes.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam int DATA_W = 8;

    localparam logic [10:0] CMD_ADDR_A = 11'h555;
    localparam logic [10:0] CMD_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_FIRST  = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  OP_PROGRAM = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  ERASE_CONF = 8'h30;

    typedef enum logic [2:0] {
        CS_READ,
        CS_UNLK1,
        CS_UNLK2,
        CS_PGM,
        CS_ERS
    } cmd_state_e;

    typedef enum logic {
        PS_IDLE,
        PS_PULSE
    } prot_state_e;

endpackage

// File: rtl/flash_wp_sync.sv
module flash_wp_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] prev;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[i] <= RST_VAL[i];
                    stage2[i] <= RST_VAL[i];
                    prev[i]   <= RST_VAL[i];
                end else begin
                    stage1[i] <= pin_in[i];
                    stage2[i] <= stage1[i];
                    prev[i]   <= stage2[i];
                end
            end
            assign rise[i] = stage2[i] & ~prev[i];
            assign fall[i] = ~stage2[i] & prev[i];
        end
    endgenerate

    assign level = stage2;

endmodule

// File: rtl/flash_wp_cmd.sv
module flash_wp_cmd
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3,
    parameter int CMD_AW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lockout,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [(1<<SECT_W)-1:0] sect_lock,
    output logic                  pgm_req,
    output logic                  ers_req,
    output logic [ADDR_W-1:0]     req_addr,
    output logic [DATA_W-1:0]     req_data,
    output logic                  in_read
);

    cmd_state_e state, nxt;
    logic fire_pgm, fire_ers;
    logic [SECT_W-1:0] sect;
    logic at_a, at_b, locked;

    assign sect   = wr_addr[ADDR_W-1 -: SECT_W];
    assign locked = sect_lock[sect];
    assign at_a   = (wr_addr[CMD_AW-1:0] == CMD_ADDR_A);
    assign at_b   = (wr_addr[CMD_AW-1:0] == CMD_ADDR_B);

    always_comb begin
        nxt      = state;
        fire_pgm = 1'b0;
        fire_ers = 1'b0;
        if (lockout) begin
            nxt = CS_READ;
        end else if (wr_stb) begin
            unique case (state)
                CS_READ:  nxt = (at_a && wr_data == KEY_FIRST) ? CS_UNLK1 : CS_READ;
                CS_UNLK1: nxt = (at_b && wr_data == KEY_SECOND) ? CS_UNLK2 : CS_READ;
                CS_UNLK2: begin
                    if (at_a && wr_data == OP_PROGRAM)    nxt = CS_PGM;
                    else if (at_a && wr_data == OP_ERASE) nxt = CS_ERS;
                    else                                  nxt = CS_READ;
                end
                CS_PGM: begin
                    nxt      = CS_READ;
                    fire_pgm = !locked;
                end
                CS_ERS: begin
                    nxt      = CS_READ;
                    fire_ers = !locked && (wr_data == ERASE_CONF);
                end
                default:  nxt = CS_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_READ;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_req  <= 1'b0;
            ers_req  <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
            in_read  <= 1'b1;
        end else begin
            pgm_req <= fire_pgm;
            ers_req <= fire_ers;
            in_read <= (nxt == CS_READ);
            if (fire_pgm || fire_ers) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flash_wp_prot.sv
module flash_wp_prot
    import flash_wp_pkg::*;
#(
    parameter int                     SECT_W    = 3,
    parameter logic [(1<<SECT_W)-1:0] PROT_INIT = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lockout,
    input  logic                   hv_mode,
    input  logic                   ce_low,
    input  logic                   we_fall,
    input  logic                   we_rise,
    input  logic [SECT_W-1:0]      sect,
    input  logic                   unprot,
    output logic [(1<<SECT_W)-1:0] sect_lock,
    output logic                   lock_op_ok
);

    localparam int NS = 1 << SECT_W;

    prot_state_e state, nxt;
    logic apply;

    always_comb begin
        nxt   = state;
        apply = 1'b0;
        unique case (state)
            PS_IDLE:  if (!lockout && hv_mode && ce_low && we_fall) nxt = PS_PULSE;
            PS_PULSE: begin
                if (lockout || !hv_mode || !ce_low) begin
                    nxt = PS_IDLE;
                end else if (we_rise) begin
                    nxt   = PS_IDLE;
                    apply = 1'b1;
                end
            end
            default:  nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_lock  <= PROT_INIT;
            lock_op_ok <= 1'b0;
        end else if (apply) begin
            if (!unprot) begin
                sect_lock[sect] <= 1'b1;
                lock_op_ok      <= 1'b1;
            end else if (&sect_lock) begin
                sect_lock  <= {NS{1'b0}};
                lock_op_ok <= 1'b1;
            end else begin
                lock_op_ok <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import flash_wp_pkg::*;
#(
    parameter int                     ADDR_W    = 19,
    parameter int                     SECT_W    = 3,
    parameter int                     CMD_AW    = 11,
    parameter int                     UNPROT_BIT = 6,
    parameter logic [(1<<SECT_W)-1:0] PROT_INIT = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_ce_n,
    input  logic                   bus_oe_n,
    input  logic                   bus_we_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_data,
    input  logic                   supply_low,
    input  logic                   hv_oe_det,
    input  logic                   hv_a9_det,
    output logic                   pgm_req,
    output logic                   ers_req,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [DATA_W-1:0]      req_data,
    output logic [(1<<SECT_W)-1:0] sect_lock,
    output logic                   lock_op_ok,
    output logic                   in_read
);

    // bit 2 = we_n, bit 1 = oe_n, bit 0 = ce_n; write-enable resets low so a
    // strobe already low at power-up never produces a falling edge
    logic [2:0] lvl, rise, fall;
    logic hv_mode, armed, wr_stb, ce_low, oe_high;

    flash_wp_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({bus_we_n, bus_oe_n, bus_ce_n}),
        .level  (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    assign hv_mode = hv_oe_det & hv_a9_det;
    assign ce_low  = ~lvl[0];
    assign oe_high = lvl[1];

    // a rising edge counts only if its falling edge was seen in a legal write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   armed <= 1'b0;
        else if (supply_low || hv_mode)               armed <= 1'b0;
        else if (fall[2] && ce_low && oe_high)        armed <= 1'b1;
        else if (rise[2] || !ce_low || !oe_high)      armed <= 1'b0;
    end

    assign wr_stb = rise[2] & armed & ce_low & oe_high & ~supply_low & ~hv_mode;

    flash_wp_cmd #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CMD_AW(CMD_AW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .lockout   (supply_low),
        .wr_stb    (wr_stb),
        .wr_addr   (bus_addr),
        .wr_data   (bus_data),
        .sect_lock (sect_lock),
        .pgm_req   (pgm_req),
        .ers_req   (ers_req),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .in_read   (in_read)
    );

    flash_wp_prot #(.SECT_W(SECT_W), .PROT_INIT(PROT_INIT)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .lockout    (supply_low),
        .hv_mode    (hv_mode),
        .ce_low     (ce_low),
        .we_fall    (fall[2]),
        .we_rise    (rise[2]),
        .sect       (bus_addr[ADDR_W-1 -: SECT_W]),
        .unprot     (bus_addr[UNPROT_BIT]),
        .sect_lock  (sect_lock),
        .lock_op_ok (lock_op_ok)
    );

endmodule

// File: rtl/flash_wp_gate_chk.sv
module flash_wp_gate_chk #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   supply_low,
    input logic                   pgm_req,
    input logic                   ers_req,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [(1<<SECT_W)-1:0] sect_lock,
    input logic                   in_read
);

    // R4: a lockout cycle leaves the tracker in read mode next cycle
    a_r4_lockout_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_low) |-> in_read);

    // R4: no request follows a lockout cycle
    a_r4_lockout_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_low) |-> (!pgm_req && !ers_req));

    // R4: protect bits frozen during lockout
    a_r4_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_low) |-> $stable(sect_lock));

    // R8: a request never targets a protected sector
    a_r8_no_req_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req || ers_req) |-> !sect_lock[req_addr[ADDR_W-1 -: SECT_W]]);

    // R5, R6: program and erase requests are exclusive
    a_r5_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_req, ers_req}));

    // R10: bits only drop all at once, and only from the fully protected value
    a_r10_clear_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((sect_lock & $past(sect_lock)) != $past(sect_lock)) |->
            (sect_lock == '0 && &$past(sect_lock)));

    // R9: a protect operation sets at most one new bit
    a_r9_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_lock != '0) |-> ($countones(sect_lock & ~$past(sect_lock)) <= 1));

endmodule

bind flash_wp_gate flash_wp_gate_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .pgm_req    (pgm_req),
    .ers_req    (ers_req),
    .req_addr   (req_addr),
    .sect_lock  (sect_lock),
    .in_read    (in_read)
);

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  data = '0;
    logic        sup_low = 1'b0, hv_oe = 1'b0, hv_a9 = 1'b0;
    logic        pgm_req, ers_req, lock_op_ok, in_read;
    logic [18:0] req_addr;
    logic [7:0]  req_data, sect_lock;

    int n_tests = 0, n_fail = 0;
    int n_pgm = 0, n_ers = 0;
    logic [18:0] last_addr = '0;
    logic [7:0]  last_data = '0;

    always #2 clk = ~clk;

    flash_wp_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_data(data),
        .supply_low(sup_low), .hv_oe_det(hv_oe), .hv_a9_det(hv_a9),
        .pgm_req(pgm_req), .ers_req(ers_req),
        .req_addr(req_addr), .req_data(req_data),
        .sect_lock(sect_lock), .lock_op_ok(lock_op_ok), .in_read(in_read)
    );

    always @(negedge clk) begin
        if (pgm_req) begin n_pgm++; last_addr = req_addr; last_data = req_data; end
        if (ers_req) begin n_ers++; last_addr = req_addr; end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d,
                      input logic ce_v = 1'b0, input logic oe_v = 1'b1);
        @(negedge clk);
        addr = a; data = d; ce_n = ce_v; oe_n = oe_v;
        cyc(2); we_n = 1'b0;
        cyc(4); we_n = 1'b1;
        cyc(4); ce_n = 1'b1; oe_n = 1'b1;
        cyc(3);
    endtask

    task automatic hv_op(input logic [2:0] sect, input logic unprot);
        @(negedge clk);
        addr = {sect, 9'd0, unprot, 6'd0}; hv_oe = 1'b1; hv_a9 = 1'b1;
        ce_n = 1'b0; oe_n = 1'b1;
        cyc(2); we_n = 1'b0;
        cyc(4); we_n = 1'b1;
        cyc(4); ce_n = 1'b1;
        cyc(1); hv_oe = 1'b0; hv_a9 = 1'b0;
        cyc(3);
    endtask

    task automatic prog_seq(input logic [18:0] a, input logic [7:0] d);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(a, d);
    endtask

    task automatic t_reset_powerup;
        int p0;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 19'h555; data = 8'hAA;
        cyc(5); rst_n = 1'b1; cyc(3);
        check("R1 in_read", in_read, 1);
        check("R1 requests", {pgm_req, ers_req}, 0);
        check("R1 sect_lock", sect_lock, 0);
        check("R1 lock_op_ok", lock_op_ok, 0);
        p0 = n_pgm;
        we_n = 1'b1; cyc(4); ce_n = 1'b1; cyc(3);
        wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(19'h00123, 8'h5A);
        check("R2 powerup strobe ignored", n_pgm - p0, 0);
    endtask

    task automatic t_program;
        int p0 = n_pgm;
        prog_seq(19'h31234, 8'hC3);
        check("R5 one pulse", n_pgm - p0, 1);
        check("R5 addr", last_addr, 19'h31234);
        check("R5 data", last_data, 8'hC3);
        check("R5 back to read", in_read, 1);
    endtask

    task automatic t_erase;
        int e0 = n_ers;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h80); wr(19'h50000, 8'h30);
        check("R6 erase pulse", n_ers - e0, 1);
        check("R6 erase addr", last_addr, 19'h50000);
        e0 = n_ers;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h80); wr(19'h50000, 8'h31);
        check("R7 bad confirm no erase", n_ers - e0, 0);
    endtask

    task automatic t_inhibit;
        int p0 = n_pgm;
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h11, 1'b0, 1'b0);
        wr(19'h2AA, 8'h22, 1'b1, 1'b1);
        wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(19'h10010, 8'h77);
        check("R3 inhibited strobes ignored", n_pgm - p0, 1);
        check("R3 data", last_data, 8'h77);
    endtask

    task automatic t_wrong;
        int p0 = n_pgm;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h12);
        check("R7 read after wrong step", in_read, 1);
        wr(19'h10000, 8'h99);
        check("R7 no request", n_pgm - p0, 0);
    endtask

    task automatic t_lockout;
        int p0 = n_pgm;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
        check("R4 mid sequence", in_read, 0);
        @(negedge clk); sup_low = 1'b1; cyc(3);
        check("R4 read during lockout", in_read, 1);
        prog_seq(19'h20000, 8'h01);
        hv_op(3'd5, 1'b0);
        check("R4 lock unchanged", sect_lock, 0);
        @(negedge clk); sup_low = 1'b0; cyc(2);
        wr(19'h555, 8'hA0); wr(19'h20000, 8'h02);
        check("R4 no request", n_pgm - p0, 0);
    endtask

    task automatic t_protect;
        int p0;
        hv_op(3'd2, 1'b0);
        check("R9 bit set", sect_lock, 8'h04);
        check("R9 ok", lock_op_ok, 1);
        check("R9 tracker untouched", in_read, 1);
        p0 = n_pgm;
        prog_seq(19'h20040, 8'h11);
        check("R8 protected dropped", n_pgm - p0, 0);
        check("R8 back to read", in_read, 1);
        prog_seq(19'h30040, 8'h12);
        check("R8 unprotected passes", n_pgm - p0, 1);
    endtask

    task automatic t_unprotect;
        hv_op(3'd0, 1'b1);
        check("R10 reject lock", sect_lock, 8'h04);
        check("R10 reject ok", lock_op_ok, 0);
        for (int s = 0; s < 8; s++) hv_op(s[2:0], 1'b0);
        check("R9 all set", sect_lock, 8'hFF);
        hv_op(3'd0, 1'b1);
        check("R10 cleared", sect_lock, 8'h00);
        check("R10 ok", lock_op_ok, 1);
    endtask

    initial begin
        t_reset_powerup();
        t_program();
        t_erase();
        t_inhibit();
        t_wrong();
        t_lockout();
        t_protect();
        t_unprotect();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule